// File: doc/BRIEF.md
# Dimension-Ordered Mesh Router

This block is the message switch of one tile in a two-dimensional mesh of tiles. It has five channels, one to the local processor and one to each of the four neighbouring tiles. Each channel is a 32-bit word path with a valid/ready handshake in each direction. A message is a header word followed by a number of payload words. The header names the destination tile and gives the payload length. The router first corrects the X coordinate and then the Y coordinate. Once a header has claimed an output, that output stays with the message until the last payload word has left.

Every incoming word is captured in a one-word input register. The word can leave through its output in the next cycle. Each router on a path therefore adds exactly one cycle, and no wire has to be longer than one tile. The tile position is fixed by parameters. When several waiting headers want the same free output, a round-robin choice decides which one gets it.

Top module: `meshXyRouter`

## Requirements
- R1: After reset, every output valid is low and every input ready is high.
- R2: Port indices are local 0, north 1, south 2, east 3, west 4. X grows eastward and Y grows southward. Header bits [1:0] hold the destination X and bits [3:2] hold the destination Y. If the destination X is greater than the tile's X, the message leaves east; if it is smaller, it leaves west. Only when X matches does Y decide: south if the destination Y is greater, north if it is smaller.
- R3: A header whose destination equals the tile's own coordinates leaves through the local port (index 0), whichever port it arrived on.
- R4: Header bits [8:4] give the payload count n (0 to 31). The header and the n following words leave on the same output, in arrival order. With n = 0 the output is released after the header alone, and the next header from that input is routed afresh. Bits [31:9] pass through unchanged.
- R5: An output, once claimed, carries only its owner's message until the last payload word has left. Words of different messages never interleave on one output, and one input never feeds two outputs at once.
- R6: When several inputs wait for the same free output, the next input after the previous winner of that output (in rising index order, wrapping) wins. After reset the search starts at index 1.
- R7: While an output is valid and its ready is low, the output stays valid and its data stays stable. No word is lost or duplicated.
- R8: A word accepted at a clock edge is offered at its output right after that edge, so each router on a path adds one cycle. An input's ready goes low only while its register holds a word that is not leaving in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 5 | Per-channel word present on the input |
| inReady | output | 5 | Per-channel input can take a word |
| inData | input | 5x32 | Per-channel input word |
| outValid | output | 5 | Per-channel word present on the output |
| outReady | input | 5 | Per-channel downstream can take a word |
| outData | output | 5x32 | Per-channel output word |

## Verification
The assertions assume that every upstream source obeys the handshake: it keeps a word and its valid steady until ready accepts it. They also assume that every header carries a length that matches the number of words that actually follow. The bench's queue-driven sources only ever advance after an observed valid-and-ready pair, and each stimulus task builds its messages from headers whose length field counts the words pushed after them. The three-tile chain keeps the east–west links fed only by the routers themselves, so the same rules hold on the internal links.

// File: rtl/meshRouterPkg.sv
package meshRouterPkg;
  localparam int NPORT  = 5;
  localparam int PSEL_W = 3;

  localparam logic [PSEL_W-1:0] P_LOCAL = 3'd0;
  localparam logic [PSEL_W-1:0] P_NORTH = 3'd1;
  localparam logic [PSEL_W-1:0] P_SOUTH = 3'd2;
  localparam logic [PSEL_W-1:0] P_EAST  = 3'd3;
  localparam logic [PSEL_W-1:0] P_WEST  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0]             inPop;
    logic [NPORT-1:0]             outActive;
    logic [NPORT-1:0][PSEL_W-1:0] outSel;
  } xbarCtrl_t;
endpackage

// File: rtl/routerRrArb.sv
module routerRrArb #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] pick,
  output logic             found
);
  // search last+1, last+2, ... wrapping; nearest requester wins
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = N; k >= 1; k--) begin
      if (req[(int'(last) + k) % N]) begin
        found = 1'b1;
        pick  = IDX_W'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/routerDatapath.sv
module routerDatapath
  import meshRouterPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             inValid,
  output logic [NPORT-1:0]             inReady,
  input  logic [NPORT-1:0][DATA_W-1:0] inData,
  input  xbarCtrl_t                    ctrl,
  output logic [NPORT-1:0]             holdValid,
  output logic [NPORT-1:0][DATA_W-1:0] holdData,
  output logic [NPORT-1:0]             outValid,
  output logic [NPORT-1:0][DATA_W-1:0] outData
);
  for (genvar i = 0; i < NPORT; i++) begin : g_hold
    logic              vR;
    logic [DATA_W-1:0] dR;
    logic              take;

    assign inReady[i] = !vR || ctrl.inPop[i];
    assign take       = inValid[i] && inReady[i];

    always_ff @(posedge clk) begin
      if (rst)               vR <= 1'b0;
      else if (take)         vR <= 1'b1;
      else if (ctrl.inPop[i]) vR <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) dR <= inData[i];
    end

    assign holdValid[i] = vR;
    assign holdData[i]  = dR;
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_mux
    assign outValid[o] = ctrl.outActive[o] && holdValid[ctrl.outSel[o]];
    assign outData[o]  = holdData[ctrl.outSel[o]];
  end
endmodule

// File: rtl/routerCtrl.sv
module routerCtrl
  import meshRouterPkg::*;
#(
  parameter int                 DATA_W  = 32,
  parameter int                 COORD_W = 2,
  parameter int                 LEN_W   = 5,
  parameter logic [COORD_W-1:0] TILE_X  = '0,
  parameter logic [COORD_W-1:0] TILE_Y  = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             holdValid,
  input  logic [NPORT-1:0][DATA_W-1:0] holdData,
  input  logic [NPORT-1:0]             outReady,
  output xbarCtrl_t                    ctrl
);
  localparam int X_LO   = 0;
  localparam int Y_LO   = COORD_W;
  localparam int LEN_LO = 2 * COORD_W;
  localparam int CNT_W  = LEN_W + 1;

  logic [NPORT-1:0][PSEL_W-1:0] wantPort;
  logic [NPORT-1:0][CNT_W-1:0]  wantCnt;
  logic [NPORT-1:0]             inBusy;
  logic [NPORT-1:0]             inPop;
  logic [NPORT-1:0]             alloc;
  logic [NPORT-1:0][PSEL_W-1:0] owner;
  logic [NPORT-1:0]             active;
  logic [NPORT-1:0][PSEL_W-1:0] selVec;
  logic [NPORT-1:0]             popOut;

  // route decision per input: X first, then Y
  for (genvar i = 0; i < NPORT; i++) begin : g_route
    logic [COORD_W-1:0] dx, dy;
    logic [PSEL_W-1:0]  dir;
    assign dx = holdData[i][X_LO +: COORD_W];
    assign dy = holdData[i][Y_LO +: COORD_W];
    always_comb begin
      if (dx > TILE_X)      dir = P_EAST;
      else if (dx < TILE_X) dir = P_WEST;
      else if (dy > TILE_Y) dir = P_SOUTH;
      else if (dy < TILE_Y) dir = P_NORTH;
      else                  dir = P_LOCAL;
    end
    assign wantPort[i] = dir;
    assign wantCnt[i]  = CNT_W'(holdData[i][LEN_LO +: LEN_W]) + CNT_W'(1);
  end

  always_comb begin
    inBusy = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (alloc[o] && owner[o] == PSEL_W'(i)) inBusy[i] = 1'b1;
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0]  req;
    logic [PSEL_W-1:0] pick, lastWin, ownerR;
    logic              found, allocR, freshGrant;
    logic [CNT_W-1:0]  remain, cntNow, cntNext;

    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign req[i] = holdValid[i] && !inBusy[i] && (wantPort[i] == PSEL_W'(o));
    end

    routerRrArb #(.N(NPORT), .IDX_W(PSEL_W)) arb (
      .req  (req),
      .last (lastWin),
      .pick (pick),
      .found(found)
    );

    assign freshGrant = !allocR && found;
    assign active[o]  = allocR || freshGrant;
    assign selVec[o]  = allocR ? ownerR : pick;
    assign popOut[o]  = active[o] && holdValid[selVec[o]] && outReady[o];
    assign cntNow     = allocR ? remain : wantCnt[pick];
    assign cntNext    = cntNow - CNT_W'(popOut[o]);

    always_ff @(posedge clk) begin
      if (rst) begin
        allocR  <= 1'b0;
        ownerR  <= '0;
        lastWin <= '0;
        remain  <= '0;
      end else begin
        allocR <= active[o] && (cntNext != '0);
        remain <= cntNext;
        if (freshGrant) begin
          ownerR  <= pick;
          lastWin <= pick;
        end
      end
    end

    assign alloc[o] = allocR;
    assign owner[o] = ownerR;
  end

  always_comb begin
    inPop = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (popOut[o] && selVec[o] == PSEL_W'(i)) inPop[i] = 1'b1;
  end

  assign ctrl = '{inPop: inPop, outActive: active, outSel: selVec};
endmodule

// File: rtl/meshXyRouter.sv
module meshXyRouter
  import meshRouterPkg::*;
#(
  parameter int                 DATA_W  = 32,
  parameter int                 COORD_W = 2,
  parameter int                 LEN_W   = 5,
  parameter logic [COORD_W-1:0] TILE_X  = '0,
  parameter logic [COORD_W-1:0] TILE_Y  = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             inValid,
  output logic [NPORT-1:0]             inReady,
  input  logic [NPORT-1:0][DATA_W-1:0] inData,
  output logic [NPORT-1:0]             outValid,
  input  logic [NPORT-1:0]             outReady,
  output logic [NPORT-1:0][DATA_W-1:0] outData
);
  xbarCtrl_t                    xbar;
  logic [NPORT-1:0]             holdValid;
  logic [NPORT-1:0][DATA_W-1:0] holdData;

  routerCtrl #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .LEN_W(LEN_W),
    .TILE_X(TILE_X), .TILE_Y(TILE_Y)
  ) ctl (
    .clk      (clk),
    .rst      (rst),
    .holdValid(holdValid),
    .holdData (holdData),
    .outReady (outReady),
    .ctrl     (xbar)
  );

  routerDatapath #(.DATA_W(DATA_W)) dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .inData   (inData),
    .ctrl     (xbar),
    .holdValid(holdValid),
    .holdData (holdData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/meshXyRouterChk.sv
module meshXyRouterChk
  import meshRouterPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             outValid,
  input logic [NPORT-1:0]             outReady,
  input logic [NPORT-1:0][DATA_W-1:0] outData,
  input xbarCtrl_t                    ctrl
);
  logic [NPORT-1:0][NPORT-1:0] feeds; // [input][output]

  always_comb begin
    feeds = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        feeds[i][o] = ctrl.outActive[o] && ctrl.outSel[o] == PSEL_W'(i);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    a_r7_hold_valid: assert property (@(posedge clk) disable iff (rst)
      outValid[o] && !outReady[o] |=> outValid[o]);
    a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
      outValid[o] && !outReady[o] |=> $stable(outData[o]));
    a_r5_owner_kept: assert property (@(posedge clk) disable iff (rst)
      ctrl.outActive[o] && !(outValid[o] && outReady[o])
      |=> ctrl.outActive[o] && $stable(ctrl.outSel[o]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    a_r5_one_output: assert property (@(posedge clk) disable iff (rst)
      $countones(feeds[i]) <= 1);
  end
endmodule

bind meshXyRouter meshXyRouterChk #(.DATA_W(DATA_W)) chk (
  .clk     (clk),
  .rst     (rst),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData),
  .ctrl    (xbar)
);

// File: tb/meshXyRouter_test.sv
module meshXyRouter_test;
  localparam int LOC = 0, NOR = 1, SOU = 2, EAS = 3, WES = 4;
  localparam int NT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [4:0]       inValid, inReady, outValid, outReady;
  logic [4:0][31:0] inData, outData;

  meshXyRouter #(.TILE_X(2'd1), .TILE_Y(2'd1)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  // three tiles in a row at y=0, linked east-west
  logic [4:0]       cInV [NT];
  logic [4:0]       cInR [NT];
  logic [4:0]       cOutV[NT];
  logic [4:0]       cOutR[NT];
  logic [4:0][31:0] cInD [NT];
  logic [4:0][31:0] cOutD[NT];
  logic             cInjV = 1'b0;
  logic [31:0]      cInjD = '0;

  for (genvar k = 0; k < NT; k++) begin : g_tile
    meshXyRouter #(.TILE_X(2'(k)), .TILE_Y(2'd0)) tile (
      .clk(clk), .rst(rst), .inValid(cInV[k]), .inReady(cInR[k]), .inData(cInD[k]),
      .outValid(cOutV[k]), .outReady(cOutR[k]), .outData(cOutD[k])
    );
    assign cInV[k][0]  = (k == 0) ? cInjV : 1'b0;
    assign cInD[k][0]  = (k == 0) ? cInjD : 32'h0;
    assign cInV[k][1]  = 1'b0;
    assign cInV[k][2]  = 1'b0;
    assign cInD[k][1]  = 32'h0;
    assign cInD[k][2]  = 32'h0;
    assign cOutR[k][0] = 1'b1;
    assign cOutR[k][1] = 1'b1;
    assign cOutR[k][2] = 1'b1;
    if (k < NT - 1) begin : g_e
      assign cInV[k][3]  = cOutV[k+1][4];
      assign cInD[k][3]  = cOutD[k+1][4];
      assign cOutR[k][3] = cInR[k+1][4];
    end else begin : g_en
      assign cInV[k][3]  = 1'b0;
      assign cInD[k][3]  = 32'h0;
      assign cOutR[k][3] = 1'b1;
    end
    if (k > 0) begin : g_w
      assign cInV[k][4]  = cOutV[k-1][3];
      assign cInD[k][4]  = cOutD[k-1][3];
      assign cOutR[k][4] = cInR[k-1][3];
    end else begin : g_wn
      assign cInV[k][4]  = 1'b0;
      assign cInD[k][4]  = 32'h0;
      assign cOutR[k][4] = 1'b1;
    end
  end

  int total = 0, bad = 0;
  logic [31:0] srcMem[5][16];
  int          srcCnt[5], srcPos[5];
  logic [31:0] logMem[5][32];
  int          logCnt[5];
  logic [4:0]  sinkReady;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int x, input int y, input int len, input int tag);
    return {16'(tag), 7'd0, 5'(len), 2'(y), 2'(x)};
  endfunction

  task automatic clearQ();
    for (int p = 0; p < 5; p++) begin
      srcCnt[p] = 0; srcPos[p] = 0; logCnt[p] = 0;
    end
    sinkReady = 5'h1f;
  endtask

  task automatic push(input int p, input logic [31:0] w);
    srcMem[p][srcCnt[p]] = w;
    srcCnt[p]++;
  endtask

  // drive at negedge, snapshot 1 ns later, record handshakes
  task automatic step();
    @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      inValid[p] = srcPos[p] < srcCnt[p];
      inData[p]  = inValid[p] ? srcMem[p][srcPos[p]] : 32'h0;
    end
    outReady = sinkReady;
    #1;
    for (int p = 0; p < 5; p++)
      if (inValid[p] && inReady[p]) srcPos[p]++;
    for (int o = 0; o < 5; o++)
      if (outValid[o] && outReady[o]) begin
        if (logCnt[o] < 32) logMem[o][logCnt[o]] = outData[o];
        logCnt[o]++;
      end
  endtask

  task automatic runSteps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    chk("R1 outValid after reset", 32'(outValid), 32'h0);
    chk("R1 inReady after reset", 32'(inReady), 32'h1f);
  endtask

  task automatic routeOne(input int src, input int x, input int y, input int expPort, input string tag);
    logic [31:0] h;
    int sum;
    clearQ();
    h = hdr(x, y, 0, 16'hA000 + x * 16 + y);
    push(src, h);
    runSteps(4);
    sum = 0;
    for (int o = 0; o < 5; o++) sum += logCnt[o];
    chk({tag, " word count on chosen port"}, 32'(logCnt[expPort]), 32'd1);
    chk({tag, " total words out"}, 32'(sum), 32'd1);
    if (logCnt[expPort] > 0) chk({tag, " header intact"}, logMem[expPort][0], h);
  endtask

  task automatic testRoutes();
    routeOne(LOC, 3, 1, EAS, "R2 east");
    routeOne(LOC, 0, 2, WES, "R2 west before south");
    routeOne(LOC, 1, 0, NOR, "R2 north");
    routeOne(LOC, 1, 3, SOU, "R2 south");
    routeOne(LOC, 2, 3, EAS, "R2 east before south");
    routeOne(LOC, 1, 1, LOC, "R3 local from local");
    routeOne(WES, 1, 1, LOC, "R3 local from west");
  endtask

  task automatic testFraming();
    logic [31:0] h1, h2;
    clearQ();
    h1 = hdr(0, 1, 2, 16'hB001);
    h2 = hdr(1, 0, 0, 16'hB002);
    push(LOC, h1); push(LOC, 32'h1111_0001); push(LOC, 32'h1111_0002); push(LOC, h2);
    runSteps(8);
    chk("R4 west count", 32'(logCnt[WES]), 32'd3);
    chk("R4 west header", logMem[WES][0], h1);
    chk("R4 west word1", logMem[WES][1], 32'h1111_0001);
    chk("R4 west word2", logMem[WES][2], 32'h1111_0002);
    chk("R4 next header rerouted north", 32'(logCnt[NOR]), 32'd1);
    chk("R4 north header", logMem[NOR][0], h2);
  endtask

  task automatic testContention();
    logic [31:0] exp[8];
    clearQ();
    exp[0] = hdr(3, 1, 2, 16'hC0A1); exp[1] = 32'hAAAA_0001; exp[2] = 32'hAAAA_0002;
    exp[3] = hdr(3, 1, 1, 16'hC0B1); exp[4] = 32'hBBBB_0001;
    exp[5] = hdr(3, 1, 1, 16'hC0A2); exp[6] = 32'hAAAA_0003;
    exp[7] = hdr(3, 1, 0, 16'hC0B2);
    push(NOR, exp[0]); push(NOR, exp[1]); push(NOR, exp[2]); push(NOR, exp[5]); push(NOR, exp[6]);
    push(SOU, exp[3]); push(SOU, exp[4]); push(SOU, exp[7]);
    runSteps(14);
    chk("R5 east word count", 32'(logCnt[EAS]), 32'd8);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R5 R6 east word %0d", k), logMem[EAS][k], exp[k]);
  endtask

  task automatic testBackpressure();
    logic [31:0] h1, h2, snap;
    clearQ();
    h1 = hdr(0, 1, 1, 16'hD001);
    h2 = hdr(0, 1, 0, 16'hD002);
    push(LOC, h1); push(LOC, 32'hDDDD_0001); push(LOC, h2);
    sinkReady[WES] = 1'b0;
    runSteps(3);
    chk("R7 stalled output valid", 32'(outValid[WES]), 32'd1);
    chk("R7 stalled output data", outData[WES], h1);
    chk("R8 input ready low while full", 32'(inReady[LOC]), 32'd0);
    snap = outData[WES];
    runSteps(2);
    chk("R7 still valid", 32'(outValid[WES]), 32'd1);
    chk("R7 data stable", outData[WES], snap);
    chk("R7 nothing taken while stalled", 32'(logCnt[WES]), 32'd0);
    sinkReady[WES] = 1'b1;
    runSteps(6);
    chk("R7 all words after release", 32'(logCnt[WES]), 32'd3);
    chk("R7 word0", logMem[WES][0], h1);
    chk("R7 word1", logMem[WES][1], 32'hDDDD_0001);
    chk("R7 word2", logMem[WES][2], h2);
  endtask

  task automatic testChain();
    logic [31:0] h;
    h = hdr(2, 0, 0, 16'hE001);
    @(negedge clk);
    cInjV = 1'b1; cInjD = h;
    #1;
    chk("R8 tile0 local ready", 32'(cInR[0][0]), 32'd1);
    @(negedge clk);
    cInjV = 1'b0;
    #1;
    chk("R8 tile0 east valid after one edge", 32'(cOutV[0][3]), 32'd1);
    chk("R8 tile2 not yet after one edge", 32'(cOutV[2][0]), 32'd0);
    @(negedge clk); #1;
    chk("R8 tile2 not yet after two edges", 32'(cOutV[2][0]), 32'd0);
    chk("R3 tile1 keeps passing through", 32'(cOutV[1][0]), 32'd0);
    @(negedge clk); #1;
    chk("R8 tile2 local valid after three edges", 32'(cOutV[2][0]), 32'd1);
    chk("R8 tile2 local data", cOutD[2][0], h);
    @(negedge clk); #1;
    chk("R8 tile2 local drained", 32'(cOutV[2][0]), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    inValid = '0; inData = '0; outReady = 5'h1f;
    clearQ();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testRoutes();
    testFraming();
    testContention();
    testBackpressure();
    testChain();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule